// File: doc/BRIEF.md
# Multiplexed Grid Scan Timing Generator

This block produces the time-multiplexed scan for a grid-and-anode display from a single system clock. A prescaler divides the clock into a base time unit. Each digit slot lasts a fixed 64 units. Within a slot, exactly one grid output may be driven. It is driven for a share of the slot set by a 4-bit brightness code and is then held off. At the end of every slot the scan moves on to the next digit. It wraps back to the first digit after the last digit that has been enabled.

The segment data path reads the current digit index to fetch the pattern for the active grid. It uses the display-active output to know when the grid is actually lit. The brightness code and the digit-count code are sampled only at slot boundaries, so a change cannot shorten or stretch a grid pulse that is already running.

The control state machine has two states. SCAN_LIT means the grid of the current digit is on. SCAN_DARK means all grids are off. Four transitions connect them:
- LIT_TIMEOUT (SCAN_LIT to SCAN_DARK) fires when the on-time for the latched brightness has elapsed.
- SLOT_NEXT_LIT (either state to SCAN_LIT) fires at a slot boundary when the newly sampled brightness is non-zero.
- SLOT_NEXT_DARK (either state to SCAN_DARK) fires at a slot boundary when the newly sampled brightness is zero.
- HOLD keeps the current state on every other cycle.

Reset puts the machine in SCAN_DARK.

Top module: `vfd_grid_scan`

## Requirements
- R1: While reset is asserted, and for the whole first slot after it is released, all grid outputs, `disp_active` and `digit_idx` are 0. Reset latches a brightness of 0 and a digit count of 16.
- R2: One time unit lasts TICK_DIV clock cycles. One digit slot lasts 64 time units, whatever the digit count.
- R3: With a latched brightness code b, the grid of the current digit is on for the first b×4 units of the slot and off for the rest. With b = 0 no grid is ever on.
- R4: At the top code (15) a grid is on for 60 units and then off for 4 units before the digit changes. Every slot ends with at least 4 dark units.
- R5: The digit index starts at 0 and increases by one at each slot boundary. After index n−1 it wraps to 0, where n is the count code sampled at that boundary. A count code of 0 means n = 16.
- R6: `grid[k]` is the only grid that can be high, and only while `digit_idx` equals k. Bit 0 is the first grid.
- R7: Changes to `duty_code` or `digit_count` take effect only at the next slot boundary. Within a slot, the digit index and the latched brightness stay constant.
- R8: If the count shrinks so that the current index is at or beyond the new limit, the next slot uses index 0.
- R9: `disp_active` is high exactly when one grid output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_code | input | 4 | Brightness code: on-time of code×4 units per 64-unit slot |
| digit_count | input | 4 | Number of digits scanned; 0 selects 16 |
| grid | output | 16 | One-hot grid enables; bit 0 is the first grid |
| digit_idx | output | 4 | Index of the digit slot in progress |
| disp_active | output | 1 | High while a grid is driven |

## Verification
The scoreboard covers several corner cases:
- The first slot after reset must stay dark even when a non-zero brightness is already applied. A design that loads the inputs at once would light a grid early.
- Brightness and count are changed in the middle of a slot. A design that samples them every cycle would cut the running grid pulse short or extend it, or would jump the index.
- The count is shrunk while the index sits beyond the new limit. A design that wraps only on equality would run past the limit.
- At the top brightness, the final 4-unit blank must appear in every slot. The one-digit case must light grid 0 in every slot.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
    typedef enum logic [0:0] {
        SCAN_DARK = 1'b0,
        SCAN_LIT  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/vfd_tick_gen.sv
module vfd_tick_gen #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (int'(cnt_q) == TICK_DIV - 1)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (int'(cnt_q) == TICK_DIV - 1);
        end
    endgenerate
endmodule

// File: rtl/vfd_slot_fsm.sv
module vfd_slot_fsm
    import vfd_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = 16,
    parameter int SLOT_UNITS = 64,
    parameter int DUTY_STEP  = 4,
    parameter int DUTY_W     = 4,
    localparam int IDX_W     = $clog2(NUM_GRIDS),
    localparam int T_W       = $clog2(SLOT_UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [IDX_W-1:0]  count_in,
    output logic [IDX_W-1:0]  dig_idx,
    output logic              lit
);
    scan_state_e       state_q, state_d;
    logic [T_W-1:0]    t_q;
    logic [IDX_W-1:0]  dig_q;
    logic [DUTY_W-1:0] duty_q;
    logic [IDX_W:0]    lim_q;
    logic [IDX_W:0]    new_lim;
    logic [IDX_W-1:0]  dig_nxt;
    logic              slot_end, lit_end;

    assign slot_end = tick && (int'(t_q) == SLOT_UNITS - 1);
    assign lit_end  = tick && (int'(t_q) + 1 == int'(duty_q) * DUTY_STEP);
    assign new_lim  = (count_in == '0) ? (IDX_W+1)'(NUM_GRIDS) : {1'b0, count_in};
    assign dig_nxt  = (int'(dig_q) + 1 >= int'(new_lim)) ? '0 : dig_q + 1'b1;

    // State register and slot bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_DARK;
            t_q     <= '0;
            dig_q   <= '0;
            duty_q  <= '0;
            lim_q   <= (IDX_W+1)'(NUM_GRIDS);
        end else begin
            state_q <= state_d;
            if (slot_end) begin
                t_q    <= '0;
                dig_q  <= dig_nxt;
                duty_q <= duty_in;
                lim_q  <= new_lim;
            end else if (tick) begin
                t_q <= t_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_LIT: begin
                if (slot_end)
                    state_d = (duty_in != '0) ? SCAN_LIT : SCAN_DARK;
                else if (lit_end)
                    state_d = SCAN_DARK;
            end
            SCAN_DARK: begin
                if (slot_end)
                    state_d = (duty_in != '0) ? SCAN_LIT : SCAN_DARK;
            end
            default: state_d = SCAN_DARK;
        endcase
    end

    // Outputs
    always_comb begin
        lit     = (state_q == SCAN_LIT);
        dig_idx = dig_q;
    end

    AST_LIT_NEEDS_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> (duty_q != '0)); // R3
    AST_BLANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(t_q) >= SLOT_UNITS - DUTY_STEP) |-> !lit); // R4
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, dig_q} < lim_q)); // R5
    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> $stable(dig_q)); // R7
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> $stable(duty_q)); // R7
endmodule

// File: rtl/vfd_grid_decode.sv
module vfd_grid_decode #(
    parameter int NUM_GRIDS = 16,
    localparam int IDX_W    = $clog2(NUM_GRIDS)
) (
    input  logic [IDX_W-1:0]     dig_idx,
    input  logic                 lit,
    output logic [NUM_GRIDS-1:0] grid
);
    generate
        for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
            assign grid[g] = lit && (dig_idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan #(
    parameter int TICK_DIV   = 8,
    parameter int NUM_GRIDS  = 16,
    parameter int SLOT_UNITS = 64,
    parameter int DUTY_STEP  = 4,
    parameter int DUTY_W     = 4,
    localparam int IDX_W     = $clog2(NUM_GRIDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DUTY_W-1:0]    duty_code,
    input  logic [IDX_W-1:0]     digit_count,
    output logic [NUM_GRIDS-1:0] grid,
    output logic [IDX_W-1:0]     digit_idx,
    output logic                 disp_active
);
    logic tick;
    logic lit;

    vfd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vfd_slot_fsm #(
        .NUM_GRIDS  (NUM_GRIDS),
        .SLOT_UNITS (SLOT_UNITS),
        .DUTY_STEP  (DUTY_STEP),
        .DUTY_W     (DUTY_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .duty_in  (duty_code),
        .count_in (digit_count),
        .dig_idx  (digit_idx),
        .lit      (lit)
    );

    vfd_grid_decode #(.NUM_GRIDS(NUM_GRIDS)) u_dec (
        .dig_idx (digit_idx),
        .lit     (lit),
        .grid    (grid)
    );

    assign disp_active = lit;

    AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid)); // R6
    AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active == (grid != '0)); // R9
endmodule

// File: tb/vfd_grid_scan_test.sv
module vfd_grid_scan_test;
    localparam int DIV  = 2;
    localparam int SLOT = 64;
    localparam int STEP = 4;
    localparam int SLOT_CYC = SLOT * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] duty = 4'd0;
    logic [3:0] dcount = 4'd0;
    logic [15:0] grid;
    logic [3:0] digit;
    logic active;

    always #5 clk = ~clk;

    vfd_grid_scan #(.TICK_DIV(DIV)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_code   (duty),
        .digit_count (dcount),
        .grid        (grid),
        .digit_idx   (digit),
        .disp_active (active)
    );

    typedef struct packed {
        logic [15:0] g;
        logic [3:0]  d;
        logic        a;
    } exp_t;

    exp_t  q[$];
    int    tests = 0;
    int    fails = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Inputs as seen at each rising edge
    logic [3:0] s_duty = 4'd0, s_cnt = 4'd0;
    logic       s_rst = 1'b0;
    always @(posedge clk) begin
        s_duty <= duty;
        s_cnt  <= dcount;
        s_rst  <= rst_n;
    end

    // Reference model: pushes the expected outputs after each edge
    int m_cnt = 0, m_t = 0, m_dig = 0, m_duty = 0, m_lim = 16;
    always @(negedge clk) begin
        exp_t e;
        if (!s_rst) begin
            m_cnt = 0; m_t = 0; m_dig = 0; m_duty = 0; m_lim = 16;
        end else begin
            if (m_cnt == DIV - 1) begin
                m_cnt = 0;
                if (m_t == SLOT - 1) begin
                    m_t = 0;
                    m_duty = s_duty;
                    m_lim = (s_cnt == 0) ? 16 : int'(s_cnt);
                    m_dig = (m_dig + 1 >= m_lim) ? 0 : m_dig + 1;
                end else begin
                    m_t = m_t + 1;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        e.a = (m_duty != 0) && (m_t < STEP * m_duty);
        e.d = 4'(m_dig);
        e.g = e.a ? (16'd1 << m_dig) : 16'd0;
        q.push_back(e);
    end

    // Monitor: pops and compares
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0 && !done) begin
            e = q.pop_front();
            tests++;
            if (grid !== e.g) begin
                fails++;
                $display("FAIL %s R6 grid: actual %h expected %h", tag, grid, e.g);
            end
            tests++;
            if (digit !== e.d) begin
                fails++;
                $display("FAIL %s R5 digit_idx: actual %0d expected %0d", tag, digit, e.d);
            end
            tests++;
            if (active !== e.a) begin
                fails++;
                $display("FAIL %s R9 disp_active: actual %b expected %b", tag, active, e.a);
            end
        end
    end

    task automatic run_slots(input int n);
        repeat (n * SLOT_CYC) @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        duty = 4'd5;
        dcount = 4'd0;
        // First slot stays dark despite non-zero inputs (R1, R7)
        run_slots(1);
        tag = "R2 R3 R5";
        run_slots(17);
        tag = "R4";
        @(negedge clk);
        duty = 4'd15;
        dcount = 4'd4;
        run_slots(6);
        tag = "R3 R7";
        repeat (37) @(negedge clk);
        duty = 4'd0;
        run_slots(2);
        tag = "R7";
        repeat (50) @(negedge clk);
        duty = 4'd8;
        dcount = 4'd3;
        run_slots(3);
        tag = "R8";
        duty = 4'd1;
        dcount = 4'd10;
        while (digit != 4'd8) @(negedge clk);
        repeat (20) @(negedge clk);
        dcount = 4'd2;
        run_slots(4);
        tag = "R6";
        duty = 4'd9;
        dcount = 4'd1;
        run_slots(4);
        tag = "R5";
        duty = 4'd3;
        dcount = 4'd15;
        run_slots(17);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL %s watchdog: actual timeout expected completion", tag);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule